// File: doc/BRIEF.md
# Signed Fixed-Point Divider with Truncating and Flooring Fraction Formats

This block divides a signed 16-bit two's-complement dividend by a signed 16-bit two's-complement divisor. It returns an integer quotient and a 16-bit binary fraction together in one 33-bit result word. The divider works on magnitudes and produces one quotient bit per clock: 16 integer bits, then 16 fraction bits. Signs are applied once the last bit is known.

A static format input chooses how the result is split. In the truncating format, the integer is rounded toward zero and the fraction is a signed field that carries the quotient's sign. In the flooring format, the integer is the floor of the true quotient and the fraction is an unsigned value in [0, 1). In both formats the value is the integer plus the fraction, and never a concatenation of two magnitudes. Both formats are derived from one datapath result, so they always agree numerically.

Control is a start/busy/done handshake. A zero divisor is reported with a flag and an all-zero result, and the divider does not iterate in that case.

Top module: `fxdiv_dual`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are low and `result` is all zeros.
- R2: When `start` is high at a rising edge while `busy` is low and the divisor is nonzero, the operands are captured and `busy` rises. `done` is high for exactly one cycle after the 32nd rising edge that follows the capturing edge. `busy` falls at that same edge.
- R3: `start` has no effect while `busy` is high. The operation in progress completes with its own operands and its own timing.
- R4: Truncating format (`floor_mode`=0). `result[32:17]` is the quotient rounded toward zero, as 16-bit two's complement. `result[16:0]` is a 17-bit two's-complement fraction equal to ±floor(|remainder|·2^16/|divisor|), with the sign of the quotient.
- R5: Flooring format (`floor_mode`=1). `result[32:16]` is floor(dividend/divisor) as 17-bit two's complement. `result[15:0]` is an unsigned fraction of 2^16. When the quotient is negative and inexact, the fraction equals 2^16 minus the truncating fraction magnitude. Otherwise it equals that magnitude.
- R6: For any operands, integer·2^16 + fraction (each field read as signed, except the unsigned flooring fraction) gives the same value in both formats.
- R7: For -2622 / 1639, the truncating format gives integer -1 and fraction -39305 (about -0.6). The flooring format gives integer -2 and fraction 26231 (about +0.4).
- R8: A zero divisor, when accepted, sets `div_by_zero` and pulses `done` after the capturing edge itself. `busy` stays low and `result` reads all zeros. The flag clears at the next accepted start.
- R9: After `done`, `result` and `div_by_zero` stay unchanged until the next accepted start.
- R10: -32768 / -1 gives +32768 in the 17-bit flooring integer field. The 16-bit truncating integer field wraps it to 0x8000, and the fraction is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only while idle |
| floor_mode | input | 1 | Result format: 0 truncating, 1 flooring; held static |
| dividend | input | 16 | Signed dividend |
| divisor | input | 16 | Signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Last accepted request had a zero divisor |
| result | output | 33 | Packed integer and fraction, layout per format |

## Verification
The assertions check the following on every cycle: `done` is a single-cycle pulse, `busy` only falls together with `done`, captured operands hold steady while iterating, and a zero-divisor completion reads zero. They also check that the flooring and truncating words carry the same numeric value whenever a result is presented. The exact quotient and fraction bits, the 32-cycle latency, the rejection of a start during an operation and the holding of results across idle cycles can only be shown by the bench's scenarios. Those scenarios compare each result against an integer reference model over random and directed operands.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;
   typedef enum logic {
      FMT_TRUNC = 1'b0,
      FMT_FLOOR = 1'b1
   } fxdiv_fmt_e;
endpackage

// File: rtl/fxdiv_step.sv
module fxdiv_step #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] rem_in,
   input  logic          bit_in,
   input  logic [DW-1:0] mag_div,
   output logic [DW-1:0] rem_out,
   output logic          q_bit
);
   logic [DW:0] shifted;
   logic [DW:0] diff;

   always_comb begin
      shifted = {rem_in, bit_in};
      diff    = shifted - {1'b0, mag_div};
      q_bit   = ~diff[DW];
      rem_out = q_bit ? diff[DW-1:0] : shifted[DW-1:0];
   end
endmodule

// File: rtl/fxdiv_core.sv
module fxdiv_core #(
   parameter int DW = 16,
   parameter int FW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic          busy,
   output logic          done,
   output logic          dbz,
   output logic          neg,
   output logic [DW-1:0] int_mag,
   output logic [FW-1:0] frac_mag
);
   localparam int ITER = DW + FW;
   localparam int CW   = $clog2(ITER + 1);
   localparam logic [CW-1:0] LAST = CW'(ITER - 1);

   function automatic logic [DW-1:0] mag_of(input logic [DW-1:0] v);
      return v[DW-1] ? (~v + 1'b1) : v;
   endfunction

   logic            busy_q, done_q, dbz_q, neg_q;
   logic [CW-1:0]   cnt_q;
   logic [DW-1:0]   rem_q, mag_div_q;
   logic [ITER-1:0] num_q;
   logic [DW-1:0]   rem_nxt;
   logic            q_bit;
   logic            accept;

   assign accept = start && !busy_q;

   fxdiv_step #(.DW(DW)) u_step (
      .rem_in (rem_q),
      .bit_in (num_q[ITER-1]),
      .mag_div(mag_div_q),
      .rem_out(rem_nxt),
      .q_bit  (q_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         dbz_q     <= 1'b0;
         neg_q     <= 1'b0;
         cnt_q     <= '0;
         rem_q     <= '0;
         mag_div_q <= '0;
         num_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            rem_q <= '0;
            cnt_q <= '0;
            if (divisor == '0) begin
               dbz_q     <= 1'b1;
               done_q    <= 1'b1;
               neg_q     <= 1'b0;
               num_q     <= '0;
               mag_div_q <= '0;
            end else begin
               dbz_q     <= 1'b0;
               busy_q    <= 1'b1;
               neg_q     <= dividend[DW-1] ^ divisor[DW-1];
               num_q     <= {mag_of(dividend), {FW{1'b0}}};
               mag_div_q <= mag_of(divisor);
            end
         end else if (busy_q) begin
            rem_q <= rem_nxt;
            num_q <= {num_q[ITER-2:0], q_bit};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign dbz      = dbz_q;
   assign neg      = neg_q;
   assign int_mag  = num_q[ITER-1:FW];
   assign frac_mag = num_q[FW-1:0];

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q && divisor != '0) |=> busy_q);
   assert_operands_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(mag_div_q));
endmodule

// File: rtl/fxdiv_pack.sv
module fxdiv_pack #(
   parameter int DW = 16,
   parameter int FW = 16
) (
   input  logic          neg,
   input  logic [DW-1:0] int_mag,
   input  logic [FW-1:0] frac_mag,
   output logic [DW:0]   int_trunc,
   output logic [FW:0]   frac_trunc,
   output logic [DW:0]   int_floor,
   output logic [FW-1:0] frac_floor,
   output logic [DW+FW:0] word_trunc,
   output logic [DW+FW:0] word_floor
);
   logic adjust;

   always_comb begin
      int_trunc  = neg ? -{1'b0, int_mag}  : {1'b0, int_mag};
      frac_trunc = neg ? -{1'b0, frac_mag} : {1'b0, frac_mag};
      adjust     = neg && (frac_mag != '0);
      int_floor  = int_trunc - {{DW{1'b0}}, adjust};
      frac_floor = adjust ? (~frac_mag + 1'b1) : frac_mag;
   end

   generate
      if (DW + FW + 1 == (DW + 1) + FW) begin : g_layout
         assign word_trunc = {int_trunc[DW-1:0], frac_trunc};
         assign word_floor = {int_floor, frac_floor};
      end
   endgenerate
endmodule

// File: rtl/fxdiv_dual.sv
module fxdiv_dual #(
   parameter int DW = 16,
   parameter int FW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            floor_mode,
   input  logic [DW-1:0]   dividend,
   input  logic [DW-1:0]   divisor,
   output logic            busy,
   output logic            done,
   output logic            div_by_zero,
   output logic [DW+FW:0]  result
);
   import fxdiv_pkg::*;

   localparam int OW = DW + FW + 1;

   generate
      if (DW < 2 || FW < 1) begin : g_bad_width
         $error("fxdiv_dual: DW must be at least 2 and FW at least 1");
      end
   endgenerate

   logic          neg;
   logic [DW-1:0] int_mag;
   logic [FW-1:0] frac_mag;
   logic [DW:0]   int_trunc, int_floor;
   logic [FW:0]   frac_trunc;
   logic [FW-1:0] frac_floor;
   logic [OW-1:0] word_trunc, word_floor;
   fxdiv_fmt_e    fmt;

   assign fmt = fxdiv_fmt_e'(floor_mode);

   fxdiv_core #(.DW(DW), .FW(FW)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .dividend(dividend),
      .divisor (divisor),
      .busy    (busy),
      .done    (done),
      .dbz     (div_by_zero),
      .neg     (neg),
      .int_mag (int_mag),
      .frac_mag(frac_mag)
   );

   fxdiv_pack #(.DW(DW), .FW(FW)) u_pack (
      .neg       (neg),
      .int_mag   (int_mag),
      .frac_mag  (frac_mag),
      .int_trunc (int_trunc),
      .frac_trunc(frac_trunc),
      .int_floor (int_floor),
      .frac_floor(frac_floor),
      .word_trunc(word_trunc),
      .word_floor(word_floor)
   );

   always_comb begin
      if (div_by_zero)           result = '0;
      else if (fmt == FMT_FLOOR) result = word_floor;
      else                       result = word_trunc;
   end

   assert_zero_on_dbz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_by_zero) |-> (result == '0 && !busy));
   assert_busy_ends_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_modes_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_by_zero) |->
      ($signed({int_floor, frac_floor}) ==
       $signed({int_trunc, {FW{1'b0}}}) + $signed({{DW{frac_trunc[FW]}}, frac_trunc})));
endmodule

// File: tb/sim_fxdiv_dual.sv
module sim_fxdiv_dual;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        floor_mode = 1'b0;
   logic [15:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        busy, done, div_by_zero;
   logic [32:0] result;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   fxdiv_dual u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .floor_mode(floor_mode),
      .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
      .div_by_zero(div_by_zero), .result(result)
   );

   function automatic logic [32:0] ref_word(input int a, input int b, input bit fl);
      int q, r, am, bm, fm, fs;
      bit ng;
      if (b == 0) return '0;
      q  = a / b;
      r  = a % b;
      am = (r < 0) ? -r : r;
      bm = (b < 0) ? -b : b;
      fm = int'((longint'(am) << 16) / bm);
      ng = (a < 0) != (b < 0);
      if (!fl) begin
         fs = ng ? -fm : fm;
         return {q[15:0], fs[16:0]};
      end
      if (r != 0 && ng) begin
         q  = q - 1;
         fm = 65536 - fm;
      end
      return {q[16:0], fm[15:0]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input int a, input int b, input bit fl,
                         output logic [32:0] res, output int lat, output bit pulse_ok);
      @(negedge clk);
      floor_mode = fl;
      dividend   = a[15:0];
      divisor    = b[15:0];
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      res = result;
      @(negedge clk);
      pulse_ok = !done;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [32:0] res, res2;
      int lat;
      bit pok;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      check(!busy && !done && !div_by_zero && result == '0, "R1", "reset state",
            {busy, done, div_by_zero, result[29:0]}, '0);
      rst_n = 1'b1;

      // R7: worked example in both formats
      run_op(-2622, 1639, 1'b0, res, lat, pok);
      check(res == {16'hFFFF, 17'h16677}, "R7", "trunc -2622/1639", res, {16'hFFFF, 17'h16677});
      check(res == ref_word(-2622, 1639, 1'b0), "R4", "trunc ref", res, ref_word(-2622, 1639, 1'b0));
      run_op(-2622, 1639, 1'b1, res2, lat, pok);
      check(res2 == {17'h1FFFE, 16'h6677}, "R7", "floor -2622/1639", res2, {17'h1FFFE, 16'h6677});
      check(res2 == ref_word(-2622, 1639, 1'b1), "R5", "floor ref", res2, ref_word(-2622, 1639, 1'b1));
      // R2: latency and pulse width
      check(lat == 33, "R2", "latency", 33'(lat), 33'd33);
      check(pok, "R2", "done single cycle", {32'b0, pok}, 33'd1);
      // R6: numeric agreement between formats
      check($signed({res[32:17], 17'b0}) / 2 + $signed({{16{res[16]}}, res[16:0]})
               == $signed({res2[32:16], 16'b0}) + $signed({17'b0, res2[15:0]}),
            "R6", "format agreement", res, res2);

      // R10: overflow corner
      run_op(-32768, -1, 1'b1, res, lat, pok);
      check(res == {17'h08000, 16'h0}, "R10", "floor -32768/-1", res, {17'h08000, 16'h0});
      run_op(-32768, -1, 1'b0, res, lat, pok);
      check(res == {16'h8000, 17'h0}, "R10", "trunc -32768/-1", res, {16'h8000, 17'h0});

      // R8: divide by zero
      run_op(1234, 0, 1'b0, res, lat, pok);
      check(res == '0 && div_by_zero, "R8", "zero divisor result", res, '0);
      check(lat == 1 && !busy, "R8", "zero divisor latency", 33'(lat), 33'd1);
      // R9: held until next start
      repeat (10) @(negedge clk);
      check(div_by_zero && result == '0, "R9", "dbz held", result, '0);
      run_op(7, -2, 1'b1, res, lat, pok);
      check(!div_by_zero && res == ref_word(7, -2, 1'b1), "R8", "flag cleared", res, ref_word(7, -2, 1'b1));
      repeat (10) @(negedge clk);
      check(result == res, "R9", "result held", result, res);

      // R3: start during busy ignored
      @(negedge clk);
      floor_mode = 1'b0; dividend = 16'd1000; divisor = 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      dividend = -16'sd5; divisor = 16'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 6;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check(result == ref_word(1000, 3, 1'b0), "R3", "ignored start operands", result, ref_word(1000, 3, 1'b0));
      check(lat == 33, "R3", "ignored start timing", 33'(lat), 33'd33);
      @(negedge clk);

      // Directed signs and zero dividend
      for (int i = 0; i < 8; i++) begin
         int a, b;
         a = (i[0]) ? -7 : 7;
         b = (i[1]) ? -2 : 2;
         if (i[2]) a = 0;
         run_op(a, b, 1'b0, res, lat, pok);
         check(res == ref_word(a, b, 1'b0), "R4", "directed trunc", res, ref_word(a, b, 1'b0));
         run_op(a, b, 1'b1, res, lat, pok);
         check(res == ref_word(a, b, 1'b1), "R5", "directed floor", res, ref_word(a, b, 1'b1));
      end

      // Random operands
      for (int i = 0; i < 200; i++) begin
         int a, b;
         bit fl;
         a  = int'($signed(16'($urandom)));
         b  = int'($signed(16'($urandom)));
         if (i % 4 == 0) b = b % 37;
         if (b == 0) b = 1;
         fl = i[0];
         run_op(a, b, fl, res, lat, pok);
         check(res == ref_word(a, b, fl), fl ? "R5" : "R4", "random", res, ref_word(a, b, fl));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule